// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This engine translates a virtual address into a physical address by reading a tree of page tables from memory. A translation request carries the virtual address, and a root-table base is supplied alongside it. The engine reads one table entry per level over a plain request/response memory port. Each valid entry either points at the next table down or, at the bottom level, holds the physical page number. An invalid entry at any depth stops the walk and raises a page fault. The fault response carries the virtual address that missed and the depth where the walk stopped.

The virtual page number is cut into equal index fields, one for each level. The most significant field indexes the root table. The page offset is carried into the physical address unchanged. Entries are 32-bit words, so each entry address is the table base plus four times the index. The engine handles one translation at a time. Choosing victims, fetching pages and writing tables are left to system software.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `mem_req_valid` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: The entry read at level i has address base_i + 4*field_i. Field 0 is the most significant index field of the virtual page number: bits 31:22 with the defaults, and bits 21:12 for level 1.
- R3: At a non-final level, a valid entry gives the next table base as entry bits 31:12 with twelve zero bits appended. Entry bits 11:1 are ignored.
- R4: At the final level, a valid entry gives the physical address as entry bits 31:12 joined with virtual address bits 11:0.
- R5: An entry whose bit 0 is 0 ends the walk with `rsp_fault`=1. It reports the request's virtual address on `rsp_fault_vaddr` and the 0-based level on `rsp_fault_level`, and no further entries are read.
- R6: The root base is taken from `ptbr` in the cycle the request is accepted. Later changes to `ptbr` do not affect that walk.
- R7: `busy` is 1 from the cycle after acceptance through the cycle with `rsp_valid`. `req_ready` is 0 for that time, and requests offered then are not accepted.
- R8: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long.
- R9: A memory read request that is not accepted keeps `mem_req_valid` high and holds `mem_req_addr` steady until `mem_req_ready`.
- R10: At most one memory read is outstanding. A successful walk makes exactly one read per level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_vaddr | input | VA_W | Virtual address to translate |
| ptbr | input | PA_W | Root table base, sampled on acceptance |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault_vaddr | output | VA_W | Virtual address of the request |
| rsp_fault_level | output | LVL_W | Level where the walk stopped |

## Verification
A stale table base or a wrong level counter appears at the ports within one memory round trip. The next `mem_req_addr` points at the wrong entry, and the walk then faults at an unexpected level or returns a wrong physical page. A fault flag latched at the wrong time shows on the single result pulse. A state machine that fails to return to idle shows as `req_ready` staying low, or as a missing or doubled `rsp_valid` pulse. Counting reads per walk catches a walk that continues past an invalid entry.

// File: rtl/ptw_pkg.sv
// Shared definitions for the page table walker.
// Assumes 32-bit table entries with the valid flag in bit 0.
package ptw_pkg;
    localparam int PTE_W        = 32;
    localparam int PTE_SHIFT    = 2;   // log2 of the entry size in bytes
    localparam int PTE_VALID_IX = 0;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_ISSUE = 2'd1,
        WALK_WAIT  = 2'd2,
        WALK_DONE  = 2'd3
    } walk_state_t;
endpackage

// File: rtl/ptw_field_sel.sv
// Picks the index field of the virtual page number used at a given level.
// Assumes the page number width divides evenly by LEVELS; level 0 takes
// the most significant field.
module ptw_field_sel #(
    parameter int VA_W   = 32,
    parameter int OFS_W  = 12,
    parameter int LEVELS = 2,
    parameter int FIELD_W = (VA_W - OFS_W) / LEVELS,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VA_W-1:0]    vaddr,
    input  logic [LVL_W-1:0]   level,
    output logic [FIELD_W-1:0] field
);
    logic [FIELD_W-1:0] slices [LEVELS];

    // one slice per level, most significant first
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slices[g] = vaddr[VA_W-1-g*FIELD_W -: FIELD_W];
    end

    // select the slice for the current level
    always_comb begin
        field = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) field = slices[i];
        end
    end
endmodule

// File: rtl/ptw_pte_addr.sv
// Forms the byte address of a table entry from a table base and an index.
// Assumes the index, scaled by the entry size, fits in PA_W bits.
module ptw_pte_addr
    import ptw_pkg::*;
#(
    parameter int PA_W    = 32,
    parameter int FIELD_W = 10
) (
    input  logic [PA_W-1:0]    base,
    input  logic [FIELD_W-1:0] index,
    output logic [PA_W-1:0]    addr
);
    // base plus index times entry size
    assign addr = base + (PA_W'(index) << PTE_SHIFT);
endmodule

// File: rtl/ptw_pte_decode.sv
// Splits a table entry into its valid flag and its page-aligned frame base.
// Assumes PA_W <= 32; entry bits below the page offset other than the
// valid flag carry nothing the walker uses.
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int OFS_W = 12
) (
    input  logic [PTE_W-1:0]      pte,
    output logic                  valid,
    output logic [PA_W-OFS_W-1:0] frame,
    output logic [PA_W-1:0]       frame_base
);
    // extract flag and frame number
    always_comb begin
        valid      = pte[PTE_VALID_IX];
        frame      = pte[PA_W-1:OFS_W];
        frame_base = {pte[PA_W-1:OFS_W], {OFS_W{1'b0}}};
    end
endmodule

// File: rtl/ptw_walker.sv
// Multi-level page table walker. Accepts one translation at a time, reads
// one entry per level through a valid/ready request port with a separate
// response strobe, and returns a physical address or a fault with the
// level reached. Assumes the memory returns exactly one response per
// accepted read, and that no response arrives while none is outstanding.
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int OFS_W  = 12,
    parameter int LEVELS = 2,
    localparam int VPN_W   = VA_W - OFS_W,
    localparam int FIELD_W = VPN_W / LEVELS,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PA_W-1:0]   ptbr,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [VA_W-1:0]   rsp_fault_vaddr,
    output logic [LVL_W-1:0]  rsp_fault_level
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_t           state;
    logic [VA_W-1:0]       cur_vaddr;
    logic [PA_W-1:0]       cur_base;
    logic [LVL_W-1:0]      cur_level;
    logic                  res_fault;
    logic [PA_W-1:0]       res_paddr;
    logic [LVL_W-1:0]      res_level;

    logic [FIELD_W-1:0]    cur_field;
    logic [PA_W-1:0]       entry_addr;
    logic                  entry_valid;
    logic [PA_W-OFS_W-1:0] entry_frame;
    logic [PA_W-1:0]       entry_base;
    logic                  accept;

    ptw_field_sel #(
        .VA_W(VA_W), .OFS_W(OFS_W), .LEVELS(LEVELS),
        .FIELD_W(FIELD_W), .LVL_W(LVL_W)
    ) u_field (
        .vaddr(cur_vaddr), .level(cur_level), .field(cur_field)
    );

    ptw_pte_addr #(.PA_W(PA_W), .FIELD_W(FIELD_W)) u_addr (
        .base(cur_base), .index(cur_field), .addr(entry_addr)
    );

    ptw_pte_decode #(.PA_W(PA_W), .OFS_W(OFS_W)) u_dec (
        .pte(mem_rsp_data), .valid(entry_valid),
        .frame(entry_frame), .frame_base(entry_base)
    );

    // handshake and status outputs derived from the walk state
    always_comb begin
        accept          = req_valid && (state == WALK_IDLE);
        req_ready       = (state == WALK_IDLE);
        busy            = (state != WALK_IDLE);
        mem_req_valid   = (state == WALK_ISSUE);
        mem_req_addr    = entry_addr;
        rsp_valid       = (state == WALK_DONE);
        rsp_fault       = res_fault;
        rsp_paddr       = res_paddr;
        rsp_fault_vaddr = cur_vaddr;
        rsp_fault_level = res_level;
    end

    // walk sequencing: accept, issue, wait per level, then report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WALK_IDLE;
            cur_vaddr <= '0;
            cur_base  <= '0;
            cur_level <= '0;
            res_fault <= 1'b0;
            res_paddr <= '0;
            res_level <= '0;
        end else begin
            case (state)
                WALK_IDLE: begin
                    if (accept) begin
                        cur_vaddr <= req_vaddr;
                        cur_base  <= ptbr;
                        cur_level <= '0;
                        state     <= WALK_ISSUE;
                    end
                end
                WALK_ISSUE: begin
                    if (mem_req_ready) state <= WALK_WAIT;
                end
                WALK_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!entry_valid) begin
                            res_fault <= 1'b1;
                            res_paddr <= '0;
                            res_level <= cur_level;
                            state     <= WALK_DONE;
                        end else if (cur_level == LAST_LVL) begin
                            res_fault <= 1'b0;
                            res_paddr <= {entry_frame, cur_vaddr[OFS_W-1:0]};
                            res_level <= cur_level;
                            state     <= WALK_DONE;
                        end else begin
                            cur_base  <= entry_base;
                            cur_level <= cur_level + 1'b1;
                            state     <= WALK_ISSUE;
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Property checker for the page table walker, attached by bind.
// Tracks outstanding reads with a small counter of its own.
module ptw_walker_chk #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int OFS_W  = 12,
    parameter int LEVELS = 2,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             busy,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [LVL_W-1:0] rsp_fault_level
);
    logic [1:0] outst;

    // count reads issued but not yet answered
    always_ff @(posedge clk) begin
        if (!rst_n) outst <= '0;
        else begin
            case ({mem_req_valid && mem_req_ready, mem_rsp_valid})
                2'b10:   outst <= outst + 2'd1;
                2'b01:   outst <= outst - 2'd1;
                default: outst <= outst;
            endcase
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !mem_req_valid && !rsp_valid && req_ready));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    a_r5_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (int'(rsp_fault_level) < LEVELS));

    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    a_r7_result_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    a_r7_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (outst == 2'd0));

    a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= 2'd1);
endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .LEVELS(LEVELS)
) u_chk (.*);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    typedef struct packed {
        logic [31:0] va;
        logic [31:0] root;
        logic        fault;
        logic        lvl;
        logic [31:0] pa;
        logic [3:0]  reads;
    } vec_t;

    // tables: root 0x1000 -> [1]=0x2000, [2]=absent, [3]=0x3000 ; root 0x8000 -> [1]=0x3000
    localparam vec_t VECS [7] = '{
        '{32'h0040_5123, 32'h0000_1000, 1'b0, 1'b0, 32'h0ABC_D123, 4'd2},
        '{32'h0040_6FFF, 32'h0000_1000, 1'b1, 1'b1, 32'h0000_0000, 4'd2},
        '{32'h0080_0010, 32'h0000_1000, 1'b1, 1'b0, 32'h0000_0000, 4'd1},
        '{32'h007F_F000, 32'h0000_1000, 1'b0, 1'b0, 32'h1234_5000, 4'd2},
        '{32'h00C0_0ABC, 32'h0000_1000, 1'b0, 1'b0, 32'hFFFF_FABC, 4'd2},
        '{32'h0040_0777, 32'h0000_8000, 1'b0, 1'b0, 32'hFFFF_F777, 4'd2},
        '{32'h0040_0777, 32'h0000_1000, 1'b1, 1'b1, 32'h0000_0000, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [31:0] ptbr;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic [31:0] rsp_fault_vaddr;
    logic [0:0]  rsp_fault_level;

    int checks = 0;
    int errors = 0;
    int read_cnt = 0;
    int pulse_cnt = 0;
    int stall_cnt = 0;
    logic        pending = 1'b0;
    logic [31:0] pend_addr = '0;

    logic        got_fault;
    logic        got_lvl;
    logic [31:0] got_pa;
    logic [31:0] got_fva;
    logic        got;

    always #2.5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .ptbr(ptbr), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_fault_vaddr(rsp_fault_vaddr),
        .rsp_fault_level(rsp_fault_level)
    );

    function automatic logic [31:0] entry_at(input logic [31:0] a);
        case (a)
            32'h0000_1004: return 32'h0000_2001;
            32'h0000_1008: return 32'h0000_9000;
            32'h0000_100C: return 32'h0000_3001;
            32'h0000_2014: return 32'h0ABC_DFFF;
            32'h0000_2018: return 32'h5555_5000;
            32'h0000_2FFC: return 32'h1234_5001;
            32'h0000_3000: return 32'hFFFF_F001;
            32'h0000_8004: return 32'h0000_3001;
            default:       return 32'h0000_0000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and pulse monitor, stepped at falling edges
    initial begin
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (rsp_valid) pulse_cnt++;
            mem_rsp_valid = 1'b0;
            if (pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = entry_at(pend_addr);
                pending = 1'b0;
            end
            mem_req_ready = (stall_cnt == 0);
            if (stall_cnt > 0) stall_cnt--;
            if (mem_req_valid && mem_req_ready) begin
                pending   = 1'b1;
                pend_addr = mem_req_addr;
                read_cnt++;
            end
        end
    end

    // one walk: optional stray requests while busy, memory stall, root change
    task automatic walk(input logic [31:0] va, input logic [31:0] root,
                        input int stray, input int stall, input logic [31:0] root_after);
        @(negedge clk);
        req_vaddr = va;
        ptbr      = root;
        req_valid = 1'b1;
        read_cnt  = 0;
        stall_cnt = stall;
        @(negedge clk);
        check(busy && !req_ready, "R7 busy after accept", {30'd0, busy, req_ready}, 32'h2);
        ptbr      = root_after;
        req_valid = (stray > 0);
        req_vaddr = 32'h0080_0010;
        got = 1'b0;
        for (int i = 0; i < 200 && !got; i++) begin
            if (i == stray) req_valid = 1'b0;
            if (rsp_valid) begin
                got       = 1'b1;
                got_fault = rsp_fault;
                got_lvl   = rsp_fault_level;
                got_pa    = rsp_paddr;
                got_fva   = rsp_fault_vaddr;
                check(busy, "R7 busy with result", {31'd0, busy}, 32'd1);
            end else @(negedge clk);
        end
        req_valid = 1'b0;
        check(got, "R8 result returned", {31'd0, got}, 32'd1);
        @(negedge clk);
        check(!rsp_valid && !busy && req_ready, "R8 pulse one cycle and idle",
              {29'd0, rsp_valid, busy, req_ready}, 32'd1);
    endtask

    task automatic compare(input vec_t v, input string tag);
        check(got_fault == v.fault, {tag, " R5 fault flag"}, {31'd0, got_fault}, {31'd0, v.fault});
        if (v.fault) begin
            check(got_lvl == v.lvl, {tag, " R5 fault level"}, {31'd0, got_lvl}, {31'd0, v.lvl});
            check(got_fva == v.va, {tag, " R5 fault vaddr"}, got_fva, v.va);
        end else begin
            check(got_pa == v.pa, {tag, " R4 physical address"}, got_pa, v.pa);
        end
        check(read_cnt == int'(v.reads), {tag, " R10 read count"}, read_cnt, {28'd0, v.reads});
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p0;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        ptbr      = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy, "R1 busy in reset", {31'd0, busy}, 32'd0);
        check(!mem_req_valid, "R1 mem_req_valid in reset", {31'd0, mem_req_valid}, 32'd0);
        check(!rsp_valid, "R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check(req_ready, "R1 req_ready in reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && req_ready, "R1 idle after reset", {30'd0, busy, req_ready}, 32'd1);

        // table of walks: R2 indexing, R3 next base with ignored flag bits, R4, R5, R10
        for (int k = 0; k < 7; k++) begin
            walk(VECS[k].va, VECS[k].root, 0, 0, VECS[k].root);
            compare(VECS[k], $sformatf("vec%0d R2 R3", k));
        end

        // R6: root changed right after acceptance has no effect
        walk(32'h0040_5123, 32'h0000_1000, 0, 0, 32'h0000_8000);
        compare(VECS[0], "R6 root change");

        // R7: requests offered while busy are not taken
        p0 = pulse_cnt;
        walk(32'h00C0_0ABC, 32'h0000_1000, 3, 0, 32'h0000_1000);
        compare(VECS[4], "R7 stray requests");
        repeat (8) @(negedge clk);
        check(pulse_cnt - p0 == 1, "R7 R8 one result only", pulse_cnt - p0, 32'd1);
        check(read_cnt == 2, "R7 no extra reads", read_cnt, 32'd2);

        // R9: memory stalls the request
        walk(32'h007F_F000, 32'h0000_1000, 0, 4, 32'h0000_1000);
        compare(VECS[3], "R9 stalled memory");

        // R5: level-0 fault right after a stalled walk
        walk(32'h0080_0010, 32'h0000_1000, 0, 2, 32'h0000_1000);
        compare(VECS[2], "R5 stall then fault");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule